// File: doc/BRIEF.md
# Condition and Special Register Move Unit

This unit holds a 32-bit condition register and a small bank of special-purpose registers, some 64 bits wide and some 32 bits wide. It executes the four register-move instructions under primary opcode 31:

- move-to-special-register;
- move-from-special-register;
- field-masked move-to-condition-register;
- move-from-condition-register.

The unit takes an instruction word with a valid strobe and the value of a source general register. It returns a general-register write (value, index and enable) and a trap signal.

Register state updates on the clock edge that samples the valid strobe, so the next instruction already sees the new value. Write-back results and traps are registered and appear in the cycle after the strobe, as a one-cycle pulse.

Implemented special registers:

| Number | Width |
|---|---|
| 1 | 64-bit |
| 8 | 64-bit |
| 9 | 64-bit |
| 256 | 32-bit |

Number 13 is reserved as a trapping target for writes. Privilege checks and side effects of individual special registers are not modelled.

Top module: `sprmove_unit`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, gpr_we_o, trap_o, gpr_widx_o and gpr_wdata_o are 0. The condition register and all special registers reset to zero.
- R2: An instruction acts only when valid_i is 1, instr_i[31:26] equals 31 and the extended opcode instr_i[10:1] is one of 467 (move-to-special), 339 (move-from-special), 144 (move-to-condition-fields) or 19 (move-from-condition). Any other word, or valid_i low, causes no write, no trap and no state change.
- R3: The special-register number is {instr_i[15:11], instr_i[20:16]}: bits 15..11 form the upper half and bits 20..16 the lower half.
- R4: A move-to-special naming number 13 sets trap_o for one cycle, in the cycle after the strobe. It changes no register and produces no general-register write.
- R5: A move-to-special into a 64-bit register stores all 64 bits of gpr_rdata_i. Into a 32-bit register it stores only gpr_rdata_i[31:0].
- R6: A move-from-special sets gpr_we_o, with gpr_widx_o = instr_i[25:21]. gpr_wdata_o is the register value, zero-extended to 64 bits when the register is 32 bits wide.
- R7: A move-from-condition sets gpr_we_o, with gpr_widx_o = instr_i[25:21] and gpr_wdata_o = {32'b0, condition register}.
- R8: A move-to-condition-fields uses mask bit instr_i[12+j] to select condition field j, which is condition bits 4j+3..4j. A selected field takes the corresponding bits of gpr_rdata_i[31:0]; an unselected field keeps its old value.
- R9: A special-register number that is neither implemented nor 13 reads as zero, ignores writes and does not trap.
- R10: Results and traps appear exactly one cycle after the strobe and last one cycle. A state update is visible to an instruction strobed in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| valid_i | input | 1 | Instruction strobe |
| gpr_rdata_i | input | 64 | Source general-register value |
| gpr_wdata_o | output | 64 | Write-back value |
| gpr_widx_o | output | 5 | Write-back register index |
| gpr_we_o | output | 1 | Write-back enable |
| trap_o | output | 1 | Trap pulse |

## Verification
Every result of this block (write-back value, index, enable and trap) is due in the clock cycle that follows the strobed instruction. Register updates made by a strobe count for the instruction strobed in the next cycle.

The bench holds a behavioural model that applies the same one-cycle rule. It compares all four outputs at each falling edge, which is half a cycle after the result edge. Back-to-back write-then-read pairs test the visibility rule, and idle cycles test that every pulse drops after one cycle.

// File: rtl/sprmove_pkg.sv
package sprmove_pkg;
  localparam int unsigned XLEN     = 64;
  localparam int unsigned CR_W     = 32;
  localparam int unsigned SPRN_W   = 10;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned N_SPR    = 4;
  localparam int unsigned N_FIELD  = CR_W / 4;

  localparam logic [5:0] PRIMARY_OP = 6'd31;
  localparam logic [9:0] XO_MTSPR   = 10'd467;
  localparam logic [9:0] XO_MFSPR   = 10'd339;
  localparam logic [9:0] XO_MTCRF   = 10'd144;
  localparam logic [9:0] XO_MFCR    = 10'd19;
  localparam logic [SPRN_W-1:0] TRAP_SPRN = 10'd13;

  typedef enum logic [2:0] {
    OP_NONE, OP_MTSPR, OP_MFSPR, OP_MTCRF, OP_MFCR
  } op_e;

  function automatic logic [SPRN_W-1:0] spr_id(int unsigned i);
    case (i)
      0:       return 10'd1;
      1:       return 10'd8;
      2:       return 10'd9;
      default: return 10'd256;
    endcase
  endfunction

  function automatic bit spr_is_wide(int unsigned i);
    return i != 3;
  endfunction
endpackage

// File: rtl/sprmove_decode.sv
module sprmove_decode
  import sprmove_pkg::*;
(
  input  logic [31:0]          instr_i,
  input  logic                 valid_i,
  output op_e                  op_o,
  output logic [SPRN_W-1:0]    sprn_o,
  output logic [REG_IDX_W-1:0] reg_idx_o,
  output logic [N_FIELD-1:0]   fxm_o,
  output logic                 trap_o
);
  logic [9:0] xo;
  logic       prim_hit;

  assign xo        = instr_i[10:1];
  assign prim_hit  = valid_i && (instr_i[31:26] == PRIMARY_OP);
  // halves are swapped in the instruction word
  assign sprn_o    = {instr_i[15:11], instr_i[20:16]};
  assign reg_idx_o = instr_i[25:21];
  assign fxm_o     = instr_i[19:12];

  always_comb begin
    op_o = OP_NONE;
    if (prim_hit) begin
      unique case (xo)
        XO_MTSPR: op_o = OP_MTSPR;
        XO_MFSPR: op_o = OP_MFSPR;
        XO_MTCRF: op_o = OP_MTCRF;
        XO_MFCR:  op_o = OP_MFCR;
        default:  op_o = OP_NONE;
      endcase
    end
  end

  assign trap_o = (op_o == OP_MTSPR) && (sprn_o == TRAP_SPRN);
endmodule

// File: rtl/sprmove_spr_bank.sv
module sprmove_spr_bank
  import sprmove_pkg::*;
#(
  parameter int unsigned NUM  = N_SPR,
  parameter int unsigned W    = XLEN,
  parameter int unsigned NW   = SPRN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [NW-1:0] wr_num_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [NW-1:0] rd_num_i,
  output logic [W-1:0]  rd_data_o
);
  localparam int unsigned HALF = W / 2;

  logic [W-1:0] rd_vec [NUM];

  for (genvar i = 0; i < NUM; i++) begin : g_spr
    localparam logic [NW-1:0] ID   = NW'(spr_id(i));
    localparam bit            WIDE = spr_is_wide(i);
    logic wr_hit, rd_hit;
    assign wr_hit = wr_en_i && (wr_num_i == ID);
    assign rd_hit = (rd_num_i == ID);

    if (WIDE) begin : g_wide
      logic [W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q <= '0;
        else if (wr_hit) q <= wr_data_i;
      end
      assign rd_vec[i] = rd_hit ? q : '0;
    end else begin : g_narrow
      logic [HALF-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q <= '0;
        else if (wr_hit) q <= wr_data_i[HALF-1:0];
      end
      assign rd_vec[i] = rd_hit ? {{(W-HALF){1'b0}}, q} : '0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM; i++) rd_data_o |= rd_vec[i];
  end
endmodule

// File: rtl/sprmove_cr.sv
module sprmove_cr
  import sprmove_pkg::*;
#(
  parameter int unsigned W  = CR_W,
  parameter int unsigned NF = W / 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [NF-1:0] fxm_i,
  input  logic [W-1:0]  src_i,
  output logic [W-1:0]  cr_o
);
  logic [W-1:0] mask, cr_q;

  for (genvar f = 0; f < NF; f++) begin : g_mask
    assign mask[4*f +: 4] = {4{fxm_i[f]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cr_q <= '0;
    else if (wr_en_i) cr_q <= (src_i & mask) | (cr_q & ~mask);
  end

  assign cr_o = cr_q;
endmodule

// File: rtl/sprmove_unit.sv
module sprmove_unit
  import sprmove_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] instr_i,
  input  logic        valid_i,
  input  logic [63:0] gpr_rdata_i,
  output logic [63:0] gpr_wdata_o,
  output logic [4:0]  gpr_widx_o,
  output logic        gpr_we_o,
  output logic        trap_o
);
  op_e                  op;
  logic [SPRN_W-1:0]    sprn;
  logic [REG_IDX_W-1:0] reg_idx;
  logic [N_FIELD-1:0]   fxm;
  logic                 trap_req;
  logic [XLEN-1:0]      spr_rd;
  logic [CR_W-1:0]      cr;
  logic                 spr_we, cr_we, res_we;
  logic [XLEN-1:0]      res_data;

  sprmove_decode i_decode (
    .instr_i   (instr_i),
    .valid_i   (valid_i),
    .op_o      (op),
    .sprn_o    (sprn),
    .reg_idx_o (reg_idx),
    .fxm_o     (fxm),
    .trap_o    (trap_req)
  );

  assign spr_we = (op == OP_MTSPR) && !trap_req;
  assign cr_we  = (op == OP_MTCRF);

  sprmove_spr_bank #(.NUM(N_SPR), .W(XLEN), .NW(SPRN_W)) i_spr_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (spr_we),
    .wr_num_i  (sprn),
    .wr_data_i (gpr_rdata_i),
    .rd_num_i  (sprn),
    .rd_data_o (spr_rd)
  );

  sprmove_cr #(.W(CR_W), .NF(N_FIELD)) i_cr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (cr_we),
    .fxm_i   (fxm),
    .src_i   (gpr_rdata_i[CR_W-1:0]),
    .cr_o    (cr)
  );

  always_comb begin
    res_we   = 1'b0;
    res_data = '0;
    case (op)
      OP_MFSPR: begin res_we = 1'b1; res_data = spr_rd; end
      OP_MFCR:  begin res_we = 1'b1; res_data = {{(XLEN-CR_W){1'b0}}, cr}; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gpr_we_o    <= 1'b0;
      gpr_widx_o  <= '0;
      gpr_wdata_o <= '0;
      trap_o      <= 1'b0;
    end else begin
      gpr_we_o    <= res_we;
      gpr_widx_o  <= res_we ? reg_idx : '0;
      gpr_wdata_o <= res_data;
      trap_o      <= trap_req;
    end
  end
endmodule

// File: rtl/sprmove_checker.sv
module sprmove_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] instr_i,
  input logic        valid_i,
  input logic [63:0] gpr_wdata_o,
  input logic [4:0]  gpr_widx_o,
  input logic        gpr_we_o,
  input logic        trap_o
);
  a_r4_trap_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !gpr_we_o);

  a_r4_trap_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ($past(valid_i) && $past(instr_i[31:26]) == 6'd31 &&
                $past(instr_i[10:1]) == 10'd467 &&
                {$past(instr_i[15:11]), $past(instr_i[20:16])} == 10'd13));

  a_r10_we_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_we_o |-> $past(valid_i));

  a_r6_widx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_we_o |-> gpr_widx_o == $past(instr_i[25:21]));

  a_r7_mfcr_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpr_we_o && $past(instr_i[10:1]) == 10'd19) |-> gpr_wdata_o[63:32] == 32'h0);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> (!gpr_we_o && !trap_o));
endmodule

bind sprmove_unit sprmove_checker i_sprmove_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .instr_i     (instr_i),
  .valid_i     (valid_i),
  .gpr_wdata_o (gpr_wdata_o),
  .gpr_widx_o  (gpr_widx_o),
  .gpr_we_o    (gpr_we_o),
  .trap_o      (trap_o)
);

// File: tb/test_sprmove_unit.sv
`timescale 1ns/1ps
module test_sprmove_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i = '0;
  logic        valid_i = 1'b0;
  logic [63:0] gpr_rdata_i = '0;
  logic [63:0] gpr_wdata_o;
  logic [4:0]  gpr_widx_o;
  logic        gpr_we_o;
  logic        trap_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  sprmove_unit i_sprmove_unit (.*);

  // behavioural reference model
  logic [63:0] spr_m [int];
  logic [31:0] cr_m;
  logic        exp_we, exp_trap;
  logic [4:0]  exp_idx;
  logic [63:0] exp_data;
  string       exp_tag;

  function automatic int spr_kind(int n); // 0 none, 1 wide, 2 narrow
    if (n == 1 || n == 8 || n == 9) return 1;
    if (n == 256) return 2;
    return 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spr_m.delete();
      spr_m[1] = '0; spr_m[8] = '0; spr_m[9] = '0; spr_m[256] = '0;
      cr_m = '0; exp_we = 0; exp_trap = 0; exp_idx = '0; exp_data = '0;
      exp_tag = "R1";
    end else begin
      int n, xo, k;
      n  = {instr_i[15:11], instr_i[20:16]};
      xo = instr_i[10:1];
      k  = spr_kind(n);
      exp_we = 0; exp_trap = 0; exp_idx = '0; exp_data = '0; exp_tag = "R10";
      if (valid_i && instr_i[31:26] == 6'd31 && xo == 467) begin
        if (n == 13) begin exp_trap = 1; exp_tag = "R4"; end
        else if (k == 1) begin spr_m[n] = gpr_rdata_i; exp_tag = "R5"; end
        else if (k == 2) begin spr_m[n] = {32'h0, gpr_rdata_i[31:0]}; exp_tag = "R5"; end
        else exp_tag = "R9";
      end else if (valid_i && instr_i[31:26] == 6'd31 && xo == 339) begin
        exp_we = 1; exp_idx = instr_i[25:21];
        exp_data = (k != 0) ? spr_m[n] : 64'h0;
        exp_tag = (k != 0) ? "R3 R6" : "R9";
      end else if (valid_i && instr_i[31:26] == 6'd31 && xo == 19) begin
        exp_we = 1; exp_idx = instr_i[25:21]; exp_data = {32'h0, cr_m}; exp_tag = "R7";
      end else if (valid_i && instr_i[31:26] == 6'd31 && xo == 144) begin
        for (int f = 0; f < 8; f++)
          if (instr_i[12+f]) cr_m[4*f +: 4] = gpr_rdata_i[4*f +: 4];
        exp_tag = "R8";
      end else if (valid_i) exp_tag = "R2";
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(exp_tag, "we", 64'(gpr_we_o), 64'(exp_we));
      chk(exp_tag, "trap", 64'(trap_o), 64'(exp_trap));
      if (exp_we) begin
        chk(exp_tag, "idx", 64'(gpr_widx_o), 64'(exp_idx));
        chk(exp_tag, "data", gpr_wdata_o, exp_data);
      end
    end
  end

  function automatic logic [31:0] xform(int rt, int sprn, int xo);
    logic [9:0] s = 10'(sprn);
    return {6'd31, 5'(rt), s[4:0], s[9:5], 10'(xo), 1'b0};
  endfunction

  function automatic logic [31:0] crf(int rs, logic [7:0] fxm);
    return {6'd31, 5'(rs), 1'b0, fxm, 1'b0, 10'd144, 1'b0};
  endfunction

  task automatic issue(logic [31:0] ins, logic [63:0] src, bit v = 1);
    @(negedge clk_i);
    instr_i = ins; gpr_rdata_i = src; valid_i = v;
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 0; instr_i = '0; gpr_rdata_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: outputs quiet during reset
    chk("R1", "we", 64'(gpr_we_o), 0);
    chk("R1", "trap", 64'(trap_o), 0);
    chk("R1", "data", gpr_wdata_o, 0);
    chk("R1", "idx", 64'(gpr_widx_o), 0);
    rst_ni = 1;
    // R1 reset values readable
    issue(xform(3, 1, 339), '0);
    issue(xform(4, 256, 339), '0);
    issue(xform(5, 0, 19), '0);
    idle();
    // R5 R3 wide write then back-to-back read (R10)
    issue(xform(7, 1, 467), 64'hDEAD_BEEF_0123_4567);
    issue(xform(8, 1, 339), '0);
    issue(xform(2, 8, 467), 64'hA5A5_0000_FFFF_1234);
    issue(xform(2, 9, 467), 64'h1111_2222_3333_4444);
    issue(xform(9, 8, 339), '0);
    issue(xform(10, 9, 339), '0);
    // R5 narrow register keeps low half, R6 zero-extends; swap matters (256 vs 8)
    issue(xform(1, 256, 467), 64'hFFFF_FFFF_CAFE_F00D);
    issue(xform(11, 256, 339), '0);
    issue(xform(12, 8, 339), '0);
    idle();
    // R4 trap write, then state unchanged
    issue(xform(1, 13, 467), 64'h5555_5555_5555_5555);
    idle();
    issue(xform(13, 13, 339), '0);
    issue(xform(13, 1, 339), '0);
    // R9 unimplemented number
    issue(xform(1, 500, 467), 64'h7777_7777_7777_7777);
    issue(xform(14, 500, 339), '0);
    issue(xform(15, 12, 339), '0);
    // R8 field masks, R7 read back
    issue(crf(1, 8'hFF), 64'h9999_9999_8765_4321);
    issue(xform(16, 0, 19), '0);
    issue(crf(1, 8'h05), 64'h0000_0000_ABCD_EF98);
    issue(xform(17, 0, 19), '0);
    issue(crf(1, 8'h80), 64'h0000_0000_F000_0000);
    issue(xform(18, 0, 19), '0);
    issue(crf(1, 8'h00), 64'hFFFF_FFFF_FFFF_FFFF);
    issue(xform(19, 0, 19), '0);
    // R2 ignored words
    issue({6'd30, xform(1, 1, 467)} & 32'h7BFF_FFFF | 32'h7800_0000, 64'h1);
    issue(xform(1, 1, 466), 64'h2);
    issue(xform(1, 1, 467), 64'h3, 0);
    issue(xform(20, 1, 339), '0);
    issue({6'd30, 26'(xform(21, 1, 339))}, '0);
    idle();
    idle();
    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule